// File: doc/BRIEF.md
# JTAG Test Access Port with Flash Register Access

This block is a JTAG test access port controller clocked by the test clock. It walks the standard sixteen-state TAP state machine under control of the mode-select pin, holds a sixteen-bit instruction register, and routes the serial data input and output through whichever data register the current instruction selects. Beside the usual bypass, identification and boundary-scan registers, the instruction set reaches three flash-access registers: an address register, a control register and a data register.

Toward the rest of the chip, each flash register has a parallel capture input, a parallel output and a one-cycle write strobe. A flash controller outside this block samples the outputs when a strobe fires and presents fresh values on the capture inputs for the next scan. The boundary chain is a short parameterised stub with a pin-capture input, a latched drive output and a mode flag that shows when the drive values own the pins. The serial output carries an enable that is high only while a register is being shifted. The `rstN` input is the chip's power-on reset; during normal use the TMS reset path is all that is needed.

Top module: `jtagFlashTap`

## Requirements
- R1: Five or more consecutive rising TCK edges with TMS high reach Test-Logic-Reset from any state; on leaving it the instruction register holds 0x0000, so `extestOn` is 1, and `tdoEn` is 0.
- R2: The instruction register is 16 bits wide and loads from TDI during Shift-IR, least significant bit first; Capture-IR loads 0x0001, which is the first pattern shifted out of TDO, least significant bit first.
- R3: TDO and `tdoEn` change only on the falling edge of TCK; `tdoEn` is 1 only in the half cycle following a falling edge at which the state is Shift-DR or Shift-IR.
- R4: Opcode 0xFFFF selects a one-bit bypass register that captures 0, so TDO shows a 0 and then TDI delayed by one shift.
- R5: Every opcode outside {0x0000, 0x0002, 0x0004, 0x0082, 0x0083, 0x0084, 0xFFFF} behaves as bypass.
- R6: Opcode 0x0004 selects a 32-bit identification register that captures the `IDCODE` parameter and shifts it out least significant bit first.
- R7: Opcode 0x0000 selects the boundary chain with `extestOn` high; Capture-DR loads `bsPins` and the edge leaving Update-DR copies the shifted chain to `bsDrive`.
- R8: Opcode 0x0002 selects the boundary chain with `extestOn` low, with the same capture of `bsPins` and presetting of `bsDrive`.
- R9: Opcode 0x0082 selects the address register: Capture-DR loads `flashAddrCap`; the edge leaving Update-DR copies the shifted value to `flashAddrOut` and raises `flashAddrWr` for exactly one TCK cycle.
- R10: Opcode 0x0083 selects the control register with the same capture, update and one-cycle `flashCtlWr` behaviour.
- R11: Opcode 0x0084 selects the data register with the same capture, update and one-cycle `flashDataWr` behaviour.
- R12: A scan of any register leaves the parallel outputs and strobes of the other flash registers untouched; at most one flash strobe is high at a time, and a flash output changes only with its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdoEn | output | 1 | Output enable for the TDO pad driver |
| bsPins | input | BS_LEN | Pin values captured into the boundary chain |
| bsDrive | output | BS_LEN | Latched boundary update values |
| extestOn | output | 1 | High while the boundary chain controls the pins |
| flashAddrCap | input | ADDR_W | Capture value for the address register |
| flashAddrOut | output | ADDR_W | Last updated address value |
| flashAddrWr | output | 1 | One-cycle address update strobe |
| flashCtlCap | input | CTRL_W | Capture value for the control register |
| flashCtlOut | output | CTRL_W | Last updated control value |
| flashCtlWr | output | 1 | One-cycle control update strobe |
| flashDataCap | input | DATA_W | Capture value for the data register |
| flashDataOut | output | DATA_W | Last updated data value |
| flashDataWr | output | 1 | One-cycle data update strobe |

## Verification
The hardest situation to reach is Test-Logic-Reset from the middle of a data scan with a non-reset instruction loaded, because the instruction register must be seen returning to its reset opcode without any update sequence. The stimulus loads the bypass opcode, steps into Shift-DR, and then holds TMS high for five edges, after which `extestOn` and a quiet `tdoEn` reveal the reset. A second hard case is proving that a scan of one flash register never disturbs the others, which the stimulus reaches by writing all three registers in turn and counting strobe pulses across unrelated scans.

// File: rtl/tapPkg.sv
package tapPkg;
  localparam int IR_W = 16;
  localparam logic [IR_W-1:0] OP_EXTEST  = 16'h0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 16'h0002;
  localparam logic [IR_W-1:0] OP_IDCODE  = 16'h0004;
  localparam logic [IR_W-1:0] OP_FADDR   = 16'h0082;
  localparam logic [IR_W-1:0] OP_FCTL    = 16'h0083;
  localparam logic [IR_W-1:0] OP_FDATA   = 16'h0084;
  localparam logic [IR_W-1:0] OP_BYPASS  = 16'hFFFF;
  localparam logic [IR_W-1:0] IR_RESET   = OP_EXTEST;
  localparam logic [IR_W-1:0] IR_CAPTURE = 16'h0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef enum logic [2:0] {
    SEL_BYPASS, SEL_IDCODE, SEL_BOUND, SEL_FADDR, SEL_FCTL, SEL_FDATA
  } drSel_e;

  typedef struct packed {
    logic   captureDr;
    logic   shiftDr;
    logic   updateDr;
    logic   shiftIr;
    logic   extest;
    drSel_e sel;
  } tapCtl_t;
endpackage

// File: rtl/tapCtrl.sv
module tapCtrl
  import tapPkg::*;
(
  input  logic    tck,
  input  logic    rstN,
  input  logic    tms,
  input  logic    tdi,
  output tapCtl_t ctl,
  output logic    irTdo
);
  tapState_e state, nextState;
  logic [IR_W-1:0] irShift, irReg;

  always_comb begin
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift <= '0;
      irReg   <= IR_RESET;
    end else begin
      unique case (state)
        ST_RESET:  irReg   <= IR_RESET;
        ST_CAP_IR: irShift <= IR_CAPTURE;
        ST_SH_IR:  irShift <= {tdi, irShift[IR_W-1:1]};
        ST_UPD_IR: irReg   <= irShift;
        default:   ;
      endcase
    end
  end

  always_comb begin
    ctl.captureDr = (state == ST_CAP_DR);
    ctl.shiftDr   = (state == ST_SH_DR);
    ctl.updateDr  = (state == ST_UPD_DR);
    ctl.shiftIr   = (state == ST_SH_IR);
    ctl.extest    = (irReg == OP_EXTEST);
    unique case (irReg)
      OP_EXTEST, OP_SAMPLE: ctl.sel = SEL_BOUND;
      OP_IDCODE:            ctl.sel = SEL_IDCODE;
      OP_FADDR:             ctl.sel = SEL_FADDR;
      OP_FCTL:              ctl.sel = SEL_FCTL;
      OP_FDATA:             ctl.sel = SEL_FDATA;
      default:              ctl.sel = SEL_BYPASS;
    endcase
  end

  assign irTdo = irShift[0];
endmodule

// File: rtl/tapFlashReg.sv
module tapFlashReg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         rstN,
  input  logic         tdi,
  input  logic         capture,
  input  logic         shift,
  input  logic         update,
  input  logic [W-1:0] capVal,
  output logic         serOut,
  output logic [W-1:0] parOut,
  output logic         wrStb
);
  logic [W-1:0] shReg;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parOut <= '0;
      wrStb  <= 1'b0;
    end else begin
      if (capture)    shReg <= capVal;
      else if (shift) shReg <= {tdi, shReg[W-1:1]};
      if (update) parOut <= shReg;
      wrStb <= update;
    end
  end

  assign serOut = shReg[0];
endmodule

// File: rtl/tapData.sv
module tapData
  import tapPkg::*;
#(
  parameter int          BS_LEN = 8,
  parameter int          ADDR_W = 16,
  parameter int          CTRL_W = 8,
  parameter int          DATA_W = 8,
  parameter logic [31:0] IDCODE = 32'h0A5C_3001
) (
  input  logic              tck,
  input  logic              rstN,
  input  logic              tdi,
  input  tapCtl_t           ctl,
  input  logic              irTdo,
  output logic              tdo,
  output logic              tdoEn,
  input  logic [BS_LEN-1:0] bsPins,
  output logic [BS_LEN-1:0] bsDrive,
  input  logic [ADDR_W-1:0] flashAddrCap,
  output logic [ADDR_W-1:0] flashAddrOut,
  output logic              flashAddrWr,
  input  logic [CTRL_W-1:0] flashCtlCap,
  output logic [CTRL_W-1:0] flashCtlOut,
  output logic              flashCtlWr,
  input  logic [DATA_W-1:0] flashDataCap,
  output logic [DATA_W-1:0] flashDataOut,
  output logic              flashDataWr
);
  localparam int ID_W = 32;

  logic              bypassReg;
  logic [ID_W-1:0]   idReg;
  logic [BS_LEN-1:0] bsReg;
  logic              addrSo, ctlSo, dataSo, drOut;
  logic              isAddr, isCtl, isData;

  assign isAddr = (ctl.sel == SEL_FADDR);
  assign isCtl  = (ctl.sel == SEL_FCTL);
  assign isData = (ctl.sel == SEL_FDATA);

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bypassReg <= 1'b0;
      idReg     <= '0;
      bsReg     <= '0;
      bsDrive   <= '0;
    end else begin
      if (ctl.sel == SEL_BYPASS) begin
        if (ctl.captureDr)    bypassReg <= 1'b0;
        else if (ctl.shiftDr) bypassReg <= tdi;
      end
      if (ctl.sel == SEL_IDCODE) begin
        if (ctl.captureDr)    idReg <= IDCODE;
        else if (ctl.shiftDr) idReg <= {tdi, idReg[ID_W-1:1]};
      end
      if (ctl.sel == SEL_BOUND) begin
        if (ctl.captureDr)     bsReg <= bsPins;
        else if (ctl.shiftDr)  bsReg <= {tdi, bsReg[BS_LEN-1:1]};
        if (ctl.updateDr)      bsDrive <= bsReg;
      end
    end
  end

  tapFlashReg #(.W(ADDR_W)) addrReg_i (
    .tck(tck), .rstN(rstN), .tdi(tdi),
    .capture(ctl.captureDr && isAddr), .shift(ctl.shiftDr && isAddr),
    .update(ctl.updateDr && isAddr), .capVal(flashAddrCap),
    .serOut(addrSo), .parOut(flashAddrOut), .wrStb(flashAddrWr));

  tapFlashReg #(.W(CTRL_W)) ctlReg_i (
    .tck(tck), .rstN(rstN), .tdi(tdi),
    .capture(ctl.captureDr && isCtl), .shift(ctl.shiftDr && isCtl),
    .update(ctl.updateDr && isCtl), .capVal(flashCtlCap),
    .serOut(ctlSo), .parOut(flashCtlOut), .wrStb(flashCtlWr));

  tapFlashReg #(.W(DATA_W)) dataReg_i (
    .tck(tck), .rstN(rstN), .tdi(tdi),
    .capture(ctl.captureDr && isData), .shift(ctl.shiftDr && isData),
    .update(ctl.updateDr && isData), .capVal(flashDataCap),
    .serOut(dataSo), .parOut(flashDataOut), .wrStb(flashDataWr));

  always_comb begin
    unique case (ctl.sel)
      SEL_IDCODE: drOut = idReg[0];
      SEL_BOUND:  drOut = bsReg[0];
      SEL_FADDR:  drOut = addrSo;
      SEL_FCTL:   drOut = ctlSo;
      SEL_FDATA:  drOut = dataSo;
      default:    drOut = bypassReg;
    endcase
  end

  // Output retimed to the falling edge so the far end samples on the rising edge.
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= ctl.shiftIr ? irTdo : drOut;
      tdoEn <= ctl.shiftIr | ctl.shiftDr;
    end
  end
endmodule

// File: rtl/jtagFlashTap.sv
module jtagFlashTap
  import tapPkg::*;
#(
  parameter int          BS_LEN = 8,
  parameter int          ADDR_W = 16,
  parameter int          CTRL_W = 8,
  parameter int          DATA_W = 8,
  parameter logic [31:0] IDCODE = 32'h0A5C_3001
) (
  input  logic              tck,
  input  logic              rstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdoEn,
  input  logic [BS_LEN-1:0] bsPins,
  output logic [BS_LEN-1:0] bsDrive,
  output logic              extestOn,
  input  logic [ADDR_W-1:0] flashAddrCap,
  output logic [ADDR_W-1:0] flashAddrOut,
  output logic              flashAddrWr,
  input  logic [CTRL_W-1:0] flashCtlCap,
  output logic [CTRL_W-1:0] flashCtlOut,
  output logic              flashCtlWr,
  input  logic [DATA_W-1:0] flashDataCap,
  output logic [DATA_W-1:0] flashDataOut,
  output logic              flashDataWr
);
  tapCtl_t ctl;
  logic    irTdo;

  tapCtrl ctrl_i (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .ctl(ctl), .irTdo(irTdo));

  tapData #(
    .BS_LEN(BS_LEN), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W),
    .DATA_W(DATA_W), .IDCODE(IDCODE)
  ) data_i (
    .tck(tck), .rstN(rstN), .tdi(tdi), .ctl(ctl), .irTdo(irTdo),
    .tdo(tdo), .tdoEn(tdoEn), .bsPins(bsPins), .bsDrive(bsDrive),
    .flashAddrCap(flashAddrCap), .flashAddrOut(flashAddrOut), .flashAddrWr(flashAddrWr),
    .flashCtlCap(flashCtlCap), .flashCtlOut(flashCtlOut), .flashCtlWr(flashCtlWr),
    .flashDataCap(flashDataCap), .flashDataOut(flashDataOut), .flashDataWr(flashDataWr));

  assign extestOn = ctl.extest;
endmodule

// File: rtl/jtagFlashTapChk.sv
module jtagFlashTapChk #(
  parameter int ADDR_W = 16,
  parameter int CTRL_W = 8,
  parameter int DATA_W = 8
) (
  input logic              tck,
  input logic              rstN,
  input logic              tms,
  input logic              tdoEn,
  input logic              extestOn,
  input logic [ADDR_W-1:0] flashAddrOut,
  input logic              flashAddrWr,
  input logic [CTRL_W-1:0] flashCtlOut,
  input logic              flashCtlWr,
  input logic [DATA_W-1:0] flashDataOut,
  input logic              flashDataWr
);
  logic [2:0] tmsRun;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)          tmsRun <= '0;
    else if (!tms)      tmsRun <= '0;
    else if (tmsRun != 3'd7) tmsRun <= tmsRun + 3'd1;
  end

  // R1: a long run of TMS high leaves the reset opcode in place and TDO idle
  a_r1_tms_reset: assert property (@(posedge tck) disable iff (!rstN)
    (tmsRun >= 3'd6) |-> (extestOn && !tdoEn));

  a_r9_addr_pulse: assert property (@(posedge tck) disable iff (!rstN)
    flashAddrWr |=> !flashAddrWr);
  a_r10_ctl_pulse: assert property (@(posedge tck) disable iff (!rstN)
    flashCtlWr |=> !flashCtlWr);
  a_r11_data_pulse: assert property (@(posedge tck) disable iff (!rstN)
    flashDataWr |=> !flashDataWr);

  a_r12_one_strobe: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0({flashAddrWr, flashCtlWr, flashDataWr}));
  a_r12_addr_with_strobe: assert property (@(posedge tck) disable iff (!rstN)
    !$stable(flashAddrOut) |-> flashAddrWr);
  a_r12_ctl_with_strobe: assert property (@(posedge tck) disable iff (!rstN)
    !$stable(flashCtlOut) |-> flashCtlWr);
  a_r12_data_with_strobe: assert property (@(posedge tck) disable iff (!rstN)
    !$stable(flashDataOut) |-> flashDataWr);
endmodule

bind jtagFlashTap jtagFlashTapChk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/jtagFlashTap_tb_top.sv
module jtagFlashTap_tb_top;
  localparam int          BS_LEN = 8;
  localparam int          ADDR_W = 16;
  localparam int          CTRL_W = 8;
  localparam int          DATA_W = 8;
  localparam logic [31:0] IDCODE = 32'h0A5C_3001;

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn, extestOn;
  logic [BS_LEN-1:0] bsPins = '0;
  logic [BS_LEN-1:0] bsDrive;
  logic [ADDR_W-1:0] flashAddrCap = '0;
  logic [ADDR_W-1:0] flashAddrOut;
  logic [CTRL_W-1:0] flashCtlCap = '0;
  logic [CTRL_W-1:0] flashCtlOut;
  logic [DATA_W-1:0] flashDataCap = '0;
  logic [DATA_W-1:0] flashDataOut;
  logic flashAddrWr, flashCtlWr, flashDataWr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int addrPulses = 0, ctlPulses = 0, dataPulses = 0;

  typedef struct { logic v; string req; } expBit_t;
  expBit_t expQ[$];

  always #5 tck = ~tck;

  jtagFlashTap #(
    .BS_LEN(BS_LEN), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W),
    .DATA_W(DATA_W), .IDCODE(IDCODE)
  ) dut_i (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .bsPins(bsPins), .bsDrive(bsDrive), .extestOn(extestOn),
    .flashAddrCap(flashAddrCap), .flashAddrOut(flashAddrOut), .flashAddrWr(flashAddrWr),
    .flashCtlCap(flashCtlCap), .flashCtlOut(flashCtlOut), .flashCtlWr(flashCtlWr),
    .flashDataCap(flashDataCap), .flashDataOut(flashDataOut), .flashDataWr(flashDataWr));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected TDO bits and compares before and after the rising edge.
  always @(negedge tck) begin
    #4;
    if (expQ.size() > 0) begin
      expBit_t it;
      it = expQ.pop_front();
      check(tdo === it.v, it.req, "tdo bit", {63'd0, tdo}, {63'd0, it.v});
      check(tdoEn === 1'b1, "R3", "tdoEn during shift", {63'd0, tdoEn}, 64'd1);
      @(posedge tck);
      #1;
      check(tdo === it.v, "R3", "tdo held across rising edge", {63'd0, tdo}, {63'd0, it.v});
    end
  end

  always @(negedge tck) begin
    #2;
    if (flashAddrWr) addrPulses++;
    if (flashCtlWr)  ctlPulses++;
    if (flashDataWr) dataPulses++;
  end

  task automatic step(input logic m);
    @(negedge tck);
    tms = m;
  endtask

  task automatic tapReset();
    repeat (5) step(1'b1);
    step(1'b0);
    step(1'b0);
  endtask

  task automatic shiftBits(input int n, input logic [63:0] din,
                           input logic [63:0] dexp, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge tck);
      tdi = din[k];
      tms = (k == n - 1);
      expQ.push_back('{dexp[k], req});
    end
    step(1'b1);
    step(1'b0);
    @(negedge tck);
  endtask

  task automatic scanDr(input int n, input logic [63:0] din,
                        input logic [63:0] dexp, input string req);
    step(1'b1);
    step(1'b0);
    step(1'b0);
    shiftBits(n, din, dexp, req);
  endtask

  task automatic scanIr(input logic [15:0] op);
    step(1'b1);
    step(1'b1);
    step(1'b0);
    step(1'b0);
    shiftBits(16, {48'd0, op}, 64'h0001, "R2");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pa, pc, pd;
    repeat (3) @(negedge tck);
    rstN = 1'b1;
    @(negedge tck);
    #2;
    check(tdoEn === 1'b0, "R1", "tdoEn after reset", {63'd0, tdoEn}, 64'd0);
    check(extestOn === 1'b1, "R1", "reset opcode is boundary control", {63'd0, extestOn}, 64'd1);
    check({flashAddrWr, flashCtlWr, flashDataWr} === 3'b000, "R12", "strobes at reset",
          {61'd0, flashAddrWr, flashCtlWr, flashDataWr}, 64'd0);
    tapReset();

    // R7: boundary chain under the reset opcode
    bsPins = 8'h5A;
    scanDr(8, 64'hC3, 64'h5A, "R7");
    #2;
    check(bsDrive === 8'hC3, "R7", "bsDrive after update", {56'd0, bsDrive}, 64'hC3);
    check(tdoEn === 1'b0, "R3", "tdoEn idle after scan", {63'd0, tdoEn}, 64'd0);

    // R8: sample/preload
    scanIr(16'h0002);
    #2;
    check(extestOn === 1'b0, "R8", "extestOn under sample", {63'd0, extestOn}, 64'd0);
    bsPins = 8'h96;
    scanDr(8, 64'h3C, 64'h96, "R8");
    #2;
    check(bsDrive === 8'h3C, "R8", "bsDrive preset", {56'd0, bsDrive}, 64'h3C);

    // R6: identification register
    scanIr(16'h0004);
    scanDr(32, 64'h0, {32'd0, IDCODE}, "R6");

    // R4: bypass delays TDI by one shift after a captured 0
    scanIr(16'hFFFF);
    scanDr(8, 64'hB3, {56'd0, 8'hB3 << 1}, "R4");

    // R5: unmapped opcodes fall back to bypass
    scanIr(16'h1234);
    scanDr(8, 64'h6D, {56'd0, 8'h6D << 1}, "R5");
    scanIr(16'h0085);
    scanDr(4, 64'h9, 64'h2, "R5");

    // R9: address register
    scanIr(16'h0082);
    flashAddrCap = 16'hBEEF;
    scanDr(16, 64'h1357, 64'hBEEF, "R9");
    #1;
    check(flashAddrWr === 1'b1, "R9", "address strobe high", {63'd0, flashAddrWr}, 64'd1);
    check(flashAddrOut === 16'h1357, "R9", "address output", {48'd0, flashAddrOut}, 64'h1357);
    check(flashDataOut === 8'h00 && flashCtlOut === 8'h00, "R12", "others untouched by address write",
          {48'd0, flashCtlOut, flashDataOut}, 64'd0);
    @(negedge tck);
    #1;
    check(flashAddrWr === 1'b0, "R9", "address strobe one cycle", {63'd0, flashAddrWr}, 64'd0);

    // R10: control register
    scanIr(16'h0083);
    flashCtlCap = 8'hA5;
    scanDr(8, 64'h42, 64'hA5, "R10");
    #1;
    check(flashCtlWr === 1'b1 && flashCtlOut === 8'h42, "R10", "control strobe and output",
          {55'd0, flashCtlWr, flashCtlOut}, {55'd0, 1'b1, 8'h42});
    @(negedge tck);
    #1;
    check(flashCtlWr === 1'b0, "R10", "control strobe one cycle", {63'd0, flashCtlWr}, 64'd0);

    // R11: data register
    scanIr(16'h0084);
    flashDataCap = 8'h7E;
    scanDr(8, 64'h99, 64'h7E, "R11");
    #1;
    check(flashDataWr === 1'b1 && flashDataOut === 8'h99, "R11", "data strobe and output",
          {55'd0, flashDataWr, flashDataOut}, {55'd0, 1'b1, 8'h99});
    @(negedge tck);
    #1;
    check(flashDataWr === 1'b0, "R11", "data strobe one cycle", {63'd0, flashDataWr}, 64'd0);
    check(flashAddrOut === 16'h1357 && flashCtlOut === 8'h42, "R12", "address and control kept",
          {40'd0, flashAddrOut, flashCtlOut}, {40'd0, 16'h1357, 8'h42});

    // R12: scans of other registers raise no flash strobe
    pa = addrPulses; pc = ctlPulses; pd = dataPulses;
    scanIr(16'h0004);
    scanDr(32, 64'hFFFF_FFFF, {32'd0, IDCODE}, "R6");
    scanIr(16'hFFFF);
    scanDr(4, 64'h5, 64'hA, "R4");
    @(negedge tck);
    check(addrPulses == pa && ctlPulses == pc && dataPulses == pd, "R12", "no strobe in other scans",
          64'(addrPulses + ctlPulses + dataPulses), 64'(pa + pc + pd));
    check(flashDataOut === 8'h99, "R12", "data output kept", {56'd0, flashDataOut}, 64'h99);

    // R1: reset from the middle of a bypass data scan
    step(1'b1);
    step(1'b0);
    step(1'b0);
    step(1'b0);
    #2;
    check(tdoEn === 1'b1, "R3", "tdoEn in shift", {63'd0, tdoEn}, 64'd1);
    check(extestOn === 1'b0, "R1", "bypass loaded before reset", {63'd0, extestOn}, 64'd0);
    tapReset();
    #2;
    check(extestOn === 1'b1, "R1", "reset opcode after TMS reset", {63'd0, extestOn}, 64'd1);
    check(tdoEn === 1'b0, "R1", "tdoEn after TMS reset", {63'd0, tdoEn}, 64'd0);
    check(flashDataOut === 8'h99, "R12", "TMS reset leaves data output", {56'd0, flashDataOut}, 64'h99);

    repeat (4) @(negedge tck);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule